// File: doc/BRIEF.md
# Link speed fallback sequencer

This block brings an Ethernet link up without autonegotiation. After a start request it refreshes its view of the PHY, quiets and resets the PHY, forces 100 Mb/s and then waits for link. While it waits, a periodic tick triggers a link poll. If the link does not come up within a fixed number of polls at 100 Mb/s, the block resets the PHY again, forces 10 Mb/s and polls again. If 10 Mb/s also fails, it raises a link-failure pulse and a request for the MAC to reinitialise, then goes to sleep.

All PHY access goes through a simple management request port: a one-cycle start strobe with a write flag, a 5-bit register number and 16-bit write data, and a done strobe that returns read data. An MDIO master outside this block serves that port. Only one request is outstanding at a time. The register numbers and bit positions follow the standard management register set: control is register 0 and status is register 1.

Top module: `phy_speed_fallback`

## Requirements
- R1: After reset, link_up_o, speed_100_o, link_fail_o, reinit_req_o and rst_fail_o are 0, and no request is issued until start_i is seen.
- R2: A start_i pulse accepted while asleep clears link_up_o and speed_100_o. It then issues, in this order: a read of register 1, a read of register 0, a write of 0x4C00 to register 0 (isolate bit 10, power-down bit 11, loopback bit 14) and a write of 0x8000 to register 0 (reset bit 15 alone).
- R3: After the reset write, register 0 is read repeatedly until bit 15 reads 0, with at most RST_TRIES reads (default 16). If the last allowed read still shows bit 15 set, rst_fail_o pulses for one cycle and the sequence continues.
- R4: The block then reads register 0 once and writes the value back to register 0 with bit 15 cleared, bit 13 set on the first attempt, and all other bits unchanged.
- R5: While waiting, each tick_i triggers a read of register 1 followed by a read of register 0. If bit 2 of the status value is 1, link_up_o becomes 1, speed_100_o takes bit 13 of the control value, and the block sleeps without issuing further requests.
- R6: After POLL_LIMIT (default 4) polls without link while the control value has bit 13 set, the block repeats the sequence of R2's two writes, R3 and R4, with bit 13 cleared in the speed write. The poll count restarts at zero, so 10 Mb/s also gets POLL_LIMIT polls.
- R7: After POLL_LIMIT polls without link while the control value has bit 13 clear, link_fail_o and reinit_req_o pulse together for one cycle, link_up_o stays 0, and the block sleeps.
- R8: tick_i is ignored while asleep and while a request is in progress, and start_i is ignored unless the block is asleep. Neither causes any request.
- R9: req_start_o is a one-cycle strobe. No new strobe is issued, and req_write_o, req_reg_o and req_wdata_o hold steady, until rsp_done_i answers the outstanding request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin link bring-up (accepted only while asleep) |
| tick_i | input | 1 | Poll pacing pulse |
| req_start_o | output | 1 | Management request strobe |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_reg_o | output | 5 | PHY register number |
| req_wdata_o | output | 16 | Write data |
| rsp_done_i | input | 1 | Request completed; read data valid |
| rsp_rdata_i | input | 16 | Read data |
| link_up_o | output | 1 | Link established |
| speed_100_o | output | 1 | Established link runs at 100 Mb/s |
| link_fail_o | output | 1 | One-cycle pulse: all speeds tried |
| reinit_req_o | output | 1 | One-cycle pulse: MAC reinitialisation wanted |
| rst_fail_o | output | 1 | One-cycle pulse: PHY reset bit never cleared |

## Verification
A request strobe follows the accepting edge by exactly one cycle: the edge that takes start_i, or the edge that takes rsp_done_i for the previous request, moves the sequencer to a new state, and the next edge registers the strobe. link_up_o, speed_100_o and the failure pulses change on the same edge that takes the done of the final control read of a poll. The bench's PHY model samples every strobe half a cycle after it rises and compares it against a queue of expected requests, which the stimulus pushes before it acts. The model returns done two cycles later, and the bench inspects outputs only after the queue has drained and several quiet cycles have passed. Pulses are counted on every falling edge, so a pulse cannot be missed or counted twice.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

   localparam int unsigned MG_AW = 5;
   localparam int unsigned MG_DW = 16;

   localparam logic [MG_AW-1:0] REG_CTRL = MG_AW'(0);
   localparam logic [MG_AW-1:0] REG_STAT = MG_AW'(1);

   localparam int unsigned B_RESET = 15;
   localparam int unsigned B_LOOP  = 14;
   localparam int unsigned B_SPD   = 13;
   localparam int unsigned B_PDOWN = 11;
   localparam int unsigned B_ISO   = 10;
   localparam int unsigned B_LINK  = 2;

   localparam logic [MG_DW-1:0] CTRL_QUIESCE =
      MG_DW'((1 << B_ISO) | (1 << B_PDOWN) | (1 << B_LOOP));
   localparam logic [MG_DW-1:0] CTRL_RESET = MG_DW'(1 << B_RESET);

   typedef struct packed {
      logic             wr;
      logic [MG_AW-1:0] addr;
      logic [MG_DW-1:0] data;
   } mg_op_t;

   typedef enum logic [3:0] {
      ST_ASLEEP,
      ST_RD_STAT0,
      ST_RD_CTRL0,
      ST_WR_QUIET,
      ST_WR_RST,
      ST_POLL_RST,
      ST_RD_CTRL1,
      ST_WR_SPD,
      ST_WAIT,
      ST_PL_STAT,
      ST_PL_CTRL
   } seq_st_t;

endpackage

// File: rtl/pfs_step_ctr.sv
module pfs_step_ctr #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   localparam int unsigned W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (inc_i)   cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/pfs_mgmt_port.sv
module pfs_mgmt_port
   import pfs_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             go_i,
   input  mg_op_t           op_i,
   input  logic             done_i,
   output logic             req_start_o,
   output logic             req_write_o,
   output logic [MG_AW-1:0] req_reg_o,
   output logic [MG_DW-1:0] req_wdata_o,
   output logic             fin_o
);
   logic   start_q;
   logic   busy_q;
   mg_op_t op_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         start_q <= 1'b0;
         busy_q  <= 1'b0;
         op_q    <= '0;
      end else begin
         start_q <= 1'b0;
         if (go_i && !busy_q) begin
            start_q <= 1'b1;
            busy_q  <= 1'b1;
            op_q    <= op_i;
         end else if (busy_q && done_i) begin
            busy_q  <= 1'b0;
         end
      end
   end

   assign fin_o       = busy_q && done_i;
   assign req_start_o = start_q;
   assign req_write_o = op_q.wr;
   assign req_reg_o   = op_q.addr;
   assign req_wdata_o = op_q.data;
endmodule

// File: rtl/pfs_seq_fsm.sv
module pfs_seq_fsm
   import pfs_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             tick_i,
   input  logic             fin_i,
   input  logic [MG_DW-1:0] rdata_i,
   input  logic             tick_last_i,
   input  logic             try_last_i,
   output logic             go_o,
   output mg_op_t           op_o,
   output logic             tick_clr_o,
   output logic             tick_inc_o,
   output logic             try_clr_o,
   output logic             try_inc_o,
   output logic             link_up_o,
   output logic             speed_100_o,
   output logic             link_fail_o,
   output logic             reinit_o,
   output logic             rst_fail_o
);
   seq_st_t          st_q;
   logic             issued_q;
   logic             try100_q;
   logic [MG_DW-1:0] shadow_q;
   logic             seen_link_q;
   logic             up_q, spd_q, fail_q, reinit_q, rstf_q;
   logic             is_op;
   logic             poll_miss;
   logic             rst_busy;

   always_comb begin
      is_op = 1'b1;
      op_o  = '{wr: 1'b0, addr: REG_CTRL, data: '0};
      unique case (st_q)
         ST_RD_STAT0, ST_PL_STAT: op_o.addr = REG_STAT;
         ST_WR_QUIET: op_o = '{wr: 1'b1, addr: REG_CTRL, data: CTRL_QUIESCE};
         ST_WR_RST:   op_o = '{wr: 1'b1, addr: REG_CTRL, data: CTRL_RESET};
         ST_WR_SPD: begin
            op_o.wr            = 1'b1;
            op_o.data          = shadow_q;
            op_o.data[B_RESET] = 1'b0;
            op_o.data[B_SPD]   = try100_q;
         end
         ST_RD_CTRL0, ST_POLL_RST, ST_RD_CTRL1, ST_PL_CTRL: ;
         default: is_op = 1'b0;
      endcase
   end

   assign go_o      = is_op && !issued_q;
   assign rst_busy  = rdata_i[B_RESET];
   assign poll_miss = (st_q == ST_PL_CTRL) && fin_i && !seen_link_q;

   assign try_clr_o  = (st_q == ST_WR_RST) && fin_i;
   assign try_inc_o  = (st_q == ST_POLL_RST) && fin_i && rst_busy && !try_last_i;
   assign tick_clr_o = ((st_q == ST_WR_SPD) && fin_i) || (poll_miss && tick_last_i);
   assign tick_inc_o = poll_miss && !tick_last_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q        <= ST_ASLEEP;
         issued_q    <= 1'b0;
         try100_q    <= 1'b1;
         shadow_q    <= '0;
         seen_link_q <= 1'b0;
         up_q        <= 1'b0;
         spd_q       <= 1'b0;
         fail_q      <= 1'b0;
         reinit_q    <= 1'b0;
         rstf_q      <= 1'b0;
      end else begin
         fail_q   <= 1'b0;
         reinit_q <= 1'b0;
         rstf_q   <= 1'b0;
         if (go_o)  issued_q <= 1'b1;
         if (fin_i) issued_q <= 1'b0;
         unique case (st_q)
            ST_ASLEEP: if (start_i) begin
               st_q     <= ST_RD_STAT0;
               up_q     <= 1'b0;
               spd_q    <= 1'b0;
               try100_q <= 1'b1;
            end
            ST_RD_STAT0: if (fin_i) st_q <= ST_RD_CTRL0;
            ST_RD_CTRL0: if (fin_i) st_q <= ST_WR_QUIET;
            ST_WR_QUIET: if (fin_i) st_q <= ST_WR_RST;
            ST_WR_RST:   if (fin_i) st_q <= ST_POLL_RST;
            ST_POLL_RST: if (fin_i) begin
               if (!rst_busy) begin
                  st_q <= ST_RD_CTRL1;
               end else if (try_last_i) begin
                  rstf_q <= 1'b1;
                  st_q   <= ST_RD_CTRL1;
               end
            end
            ST_RD_CTRL1: if (fin_i) begin
               shadow_q <= rdata_i;
               st_q     <= ST_WR_SPD;
            end
            ST_WR_SPD:   if (fin_i) st_q <= ST_WAIT;
            ST_WAIT:     if (tick_i) st_q <= ST_PL_STAT;
            ST_PL_STAT:  if (fin_i) begin
               seen_link_q <= rdata_i[B_LINK];
               st_q        <= ST_PL_CTRL;
            end
            ST_PL_CTRL:  if (fin_i) begin
               if (seen_link_q) begin
                  up_q  <= 1'b1;
                  spd_q <= rdata_i[B_SPD];
                  st_q  <= ST_ASLEEP;
               end else if (!tick_last_i) begin
                  st_q <= ST_WAIT;
               end else if (rdata_i[B_SPD]) begin
                  try100_q <= 1'b0;
                  st_q     <= ST_WR_QUIET;
               end else begin
                  fail_q   <= 1'b1;
                  reinit_q <= 1'b1;
                  st_q     <= ST_ASLEEP;
               end
            end
            default: st_q <= ST_ASLEEP;
         endcase
      end
   end

   assign link_up_o   = up_q;
   assign speed_100_o = spd_q;
   assign link_fail_o = fail_q;
   assign reinit_o    = reinit_q;
   assign rst_fail_o  = rstf_q;
endmodule

// File: rtl/phy_speed_fallback.sv
module phy_speed_fallback
   import pfs_pkg::*;
#(
   parameter int unsigned POLL_LIMIT = 4,
   parameter int unsigned RST_TRIES  = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             tick_i,
   output logic             req_start_o,
   output logic             req_write_o,
   output logic [MG_AW-1:0] req_reg_o,
   output logic [MG_DW-1:0] req_wdata_o,
   input  logic             rsp_done_i,
   input  logic [MG_DW-1:0] rsp_rdata_i,
   output logic             link_up_o,
   output logic             speed_100_o,
   output logic             link_fail_o,
   output logic             reinit_req_o,
   output logic             rst_fail_o
);
   if (POLL_LIMIT < 1) begin : g_bad_poll
      $error("POLL_LIMIT must be at least 1");
   end
   if (RST_TRIES < 1) begin : g_bad_tries
      $error("RST_TRIES must be at least 1");
   end
   if (MG_DW <= B_RESET) begin : g_bad_width
      $error("data width too small for control bit positions");
   end

   logic   go, fin;
   mg_op_t op;
   logic   tick_clr, tick_inc, tick_last;
   logic   try_clr, try_inc, try_last;

   pfs_seq_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .tick_i      (tick_i),
      .fin_i       (fin),
      .rdata_i     (rsp_rdata_i),
      .tick_last_i (tick_last),
      .try_last_i  (try_last),
      .go_o        (go),
      .op_o        (op),
      .tick_clr_o  (tick_clr),
      .tick_inc_o  (tick_inc),
      .try_clr_o   (try_clr),
      .try_inc_o   (try_inc),
      .link_up_o   (link_up_o),
      .speed_100_o (speed_100_o),
      .link_fail_o (link_fail_o),
      .reinit_o    (reinit_req_o),
      .rst_fail_o  (rst_fail_o)
   );

   pfs_mgmt_port u_port (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .go_i        (go),
      .op_i        (op),
      .done_i      (rsp_done_i),
      .req_start_o (req_start_o),
      .req_write_o (req_write_o),
      .req_reg_o   (req_reg_o),
      .req_wdata_o (req_wdata_o),
      .fin_o       (fin)
   );

   pfs_step_ctr #(.LIMIT(POLL_LIMIT)) u_tick_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (tick_clr),
      .inc_i  (tick_inc),
      .last_o (tick_last)
   );

   pfs_step_ctr #(.LIMIT(RST_TRIES)) u_try_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (try_clr),
      .inc_i  (try_inc),
      .last_o (try_last)
   );
endmodule

// File: rtl/pfs_sva_chk.sv
module pfs_sva_chk
   import pfs_pkg::*;
(
   input logic             clk_i,
   input logic             rst_ni,
   input logic             req_start_o,
   input logic             req_write_o,
   input logic [MG_AW-1:0] req_reg_o,
   input logic [MG_DW-1:0] req_wdata_o,
   input logic             rsp_done_i,
   input logic             link_up_o,
   input logic             link_fail_o,
   input logic             reinit_req_o,
   input logic             rst_fail_o
);
   logic out_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)          out_q <= 1'b0;
      else if (req_start_o) out_q <= 1'b1;
      else if (rsp_done_i)  out_q <= 1'b0;
   end

   a_r9_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_q |-> !req_start_o);

   a_r9_fields_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_q |-> $stable({req_write_o, req_reg_o, req_wdata_o}));

   a_r7_fail_with_reinit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_fail_o |-> reinit_req_o);

   a_r7_reinit_with_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reinit_req_o |-> link_fail_o);

   a_r7_fail_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_fail_o |=> !link_fail_o);

   a_r7_fail_link_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_fail_o |-> !link_up_o);

   a_r3_rstfail_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_fail_o |=> !rst_fail_o);

   a_r5_quiet_when_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_up_o |-> (!req_start_o && !out_q));
endmodule

bind phy_speed_fallback pfs_sva_chk u_sva_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_start_o  (req_start_o),
   .req_write_o  (req_write_o),
   .req_reg_o    (req_reg_o),
   .req_wdata_o  (req_wdata_o),
   .rsp_done_i   (rsp_done_i),
   .link_up_o    (link_up_o),
   .link_fail_o  (link_fail_o),
   .reinit_req_o (reinit_req_o),
   .rst_fail_o   (rst_fail_o)
);

// File: tb/phy_speed_fallback_tb_top.sv
`timescale 1ns/1ps
module phy_speed_fallback_tb_top;
   localparam int TRIES = 16;
   localparam logic [15:0] PHY_DEFAULT = 16'h2100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        tick = 1'b0;
   logic        req_start, req_write;
   logic [4:0]  req_reg;
   logic [15:0] req_wdata;
   logic        rsp_done = 1'b0;
   logic [15:0] rsp_rdata = 16'h0;
   logic        link_up, speed_100, link_fail, reinit_req, rst_fail;

   always #2.5 clk = ~clk;

   phy_speed_fallback dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .start_i      (start),
      .tick_i       (tick),
      .req_start_o  (req_start),
      .req_write_o  (req_write),
      .req_reg_o    (req_reg),
      .req_wdata_o  (req_wdata),
      .rsp_done_i   (rsp_done),
      .rsp_rdata_i  (rsp_rdata),
      .link_up_o    (link_up),
      .speed_100_o  (speed_100),
      .link_fail_o  (link_fail),
      .reinit_req_o (reinit_req),
      .rst_fail_o   (rst_fail)
   );

   typedef struct {
      bit    wr;
      int    addr;
      int    data;
      string tag;
   } exp_t;

   exp_t sbq[$];
   int   nchk = 0, nfail = 0, nreq = 0;
   int   fail_cnt = 0, reinit_cnt = 0, rstf_cnt = 0;
   bit   model_busy = 1'b0;
   bit   finished = 1'b0;

   logic [15:0] m_ctrl = PHY_DEFAULT;
   int          m_left = 0;
   int          m_busy_reads = 0;
   bit          m_stuck = 1'b0;
   bit          m_link100 = 1'b0;
   bit          m_link10 = 1'b0;

   task automatic chk(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic push(bit w, int a, int d, string t);
      exp_t e;
      e.wr = w; e.addr = a; e.data = d; e.tag = t;
      sbq.push_back(e);
   endtask

   task automatic push_reset(int r, bit stuck, string t);
      push(1, 0, 'h4C00, "R2");
      push(1, 0, 'h8000, "R2");
      for (int i = 0; i < (stuck ? TRIES : r + 1); i++) push(0, 0, 0, "R3");
   endtask

   task automatic push_bringup(int r, bit stuck, int spd);
      push(0, 1, 0, "R2");
      push(0, 0, 0, "R2");
      push_reset(r, stuck, "R2");
      push(0, 0, 0, "R4");
      push(1, 0, spd, "R4");
   endtask

   task automatic push_poll();
      push(0, 1, 0, "R5");
      push(0, 0, 0, "R5");
   endtask

   task automatic wait_quiet();
      while (sbq.size() != 0 || model_busy) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic poll_once();
      push_poll();
      pulse_tick();
      wait_quiet();
   endtask

   // PHY model and scoreboard monitor
   initial begin : phy_model
      exp_t        e;
      int          a, wd;
      bit          w, lk;
      logic [15:0] rd;
      logic [21:0] held;
      forever begin
         @(negedge clk);
         if (req_start) begin
            a = int'(req_reg); w = req_write; wd = int'(req_wdata);
            held = {req_write, req_reg, req_wdata};
            nreq++;
            nchk++;
            if (sbq.size() == 0) begin
               nfail++;
               $display("FAIL R8: unexpected request wr=%0d reg=%0d data=%h, expected none", w, a, wd);
            end else begin
               e = sbq.pop_front();
               if (e.wr != w || e.addr != a || (w && e.data != wd)) begin
                  nfail++;
                  $display("FAIL %s: actual wr=%0d reg=%0d data=%h expected wr=%0d reg=%0d data=%h",
                           e.tag, w, a, wd, e.wr, e.addr, e.data);
               end
            end
            model_busy = 1'b1;
            rd = 16'h0;
            if (w) begin
               if (a == 0) begin
                  if (wd[15]) begin m_ctrl = PHY_DEFAULT; m_left = m_busy_reads; end
                  else m_ctrl = wd[15:0];
               end
            end else if (a == 0) begin
               rd = m_ctrl;
               if (m_stuck || m_left > 0) begin
                  rd[15] = 1'b1;
                  if (m_left > 0) m_left--;
               end
            end else if (a == 1) begin
               lk = m_ctrl[13] ? m_link100 : m_link10;
               rd = lk ? 16'h0004 : 16'h0000;
            end
            for (int k = 0; k < 2; k++) begin
               @(negedge clk);
               nchk++;
               if (req_start || {req_write, req_reg, req_wdata} != held) begin
                  nfail++;
                  $display("FAIL R9: actual start=%0d fields=%h expected start=0 fields=%h",
                           req_start, {req_write, req_reg, req_wdata}, held);
               end
            end
            rsp_rdata = rd; rsp_done = 1'b1;
            @(negedge clk);
            rsp_done = 1'b0; rsp_rdata = 16'h0;
            model_busy = 1'b0;
         end
      end
   end

   always @(negedge clk) begin
      if (link_fail)  fail_cnt++;
      if (reinit_req) reinit_cnt++;
      if (rst_fail)   rstf_cnt++;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

   initial begin : main
      int n0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      // R1 reset state
      chk("R1 link_up", link_up, 0);
      chk("R1 speed_100", speed_100, 0);
      chk("R1 pulses", fail_cnt + reinit_cnt + rstf_cnt, 0);
      chk("R1 no request", nreq, 0);

      // R2 R3 R4 R5: link at 100 after a short reset
      m_link100 = 1; m_link10 = 0; m_busy_reads = 2;
      push_bringup(2, 0, 'h2100);
      pulse_start();
      wait_quiet();
      chk("R5 waiting link_up", link_up, 0);
      chk("R3 no rst_fail", rstf_cnt, 0);
      poll_once();
      chk("R5 link_up", link_up, 1);
      chk("R5 speed_100", speed_100, 1);

      // R8 ticks while asleep
      n0 = nreq;
      repeat (3) pulse_tick();
      repeat (10) @(negedge clk);
      chk("R8 asleep ticks no request", nreq, n0);
      chk("R8 link kept", link_up, 1);

      // R6 fallback to 10 with link at 10
      m_link100 = 0; m_link10 = 1; m_busy_reads = 0;
      push_bringup(0, 0, 'h2100);
      pulse_start();
      wait_quiet();
      chk("R2 start clears link_up", link_up, 0);
      chk("R2 start clears speed", speed_100, 0);
      repeat (3) poll_once();
      chk("R6 still waiting", link_up, 0);
      push_poll();
      push_reset(0, 0, "R6");
      push(0, 0, 0, "R6");
      push(1, 0, 'h0100, "R6");
      pulse_tick();
      wait_quiet();
      poll_once();
      chk("R6 link_up at 10", link_up, 1);
      chk("R6 speed_100 at 10", speed_100, 0);

      // R6 counter restart and R7 exhaustion
      m_link100 = 0; m_link10 = 0; m_busy_reads = 1;
      push_bringup(1, 0, 'h2100);
      pulse_start();
      wait_quiet();
      repeat (3) poll_once();
      push_poll();
      push_reset(1, 0, "R6");
      push(0, 0, 0, "R6");
      push(1, 0, 'h0100, "R6");
      pulse_tick();
      wait_quiet();
      repeat (3) poll_once();
      chk("R6 full poll budget at 10", fail_cnt, 0);
      poll_once();
      chk("R7 link_fail pulse", fail_cnt, 1);
      chk("R7 reinit pulse", reinit_cnt, 1);
      chk("R7 link down", link_up, 0);
      n0 = nreq;
      pulse_tick();
      repeat (10) @(negedge clk);
      chk("R8 tick after failure", nreq, n0);

      // R3 reset never clears
      m_link100 = 1; m_stuck = 1;
      push_bringup(0, 1, 'h2100);
      pulse_start();
      wait_quiet();
      chk("R3 rst_fail pulse", rstf_cnt, 1);
      poll_once();
      chk("R3 continues to link", link_up, 1);
      m_stuck = 0;

      // R3 boundary: clears on the last allowed read; R8 stray tick/start mid-sequence
      m_busy_reads = TRIES - 1;
      push_bringup(TRIES - 1, 0, 'h2100);
      pulse_start();
      while (!model_busy) @(negedge clk);
      pulse_tick();
      pulse_start();
      wait_quiet();
      chk("R3 boundary no rst_fail", rstf_cnt, 1);
      chk("R8 mid-sequence tick ignored", link_up, 0);
      poll_once();
      chk("R5 link_up again", link_up, 1);
      chk("R7 no extra fail", fail_cnt, 1);

      chk("R9 all requests seen", sbq.size(), 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule